// File: doc/BRIEF.md
# Trap Return Privilege Unit

This unit carries out the return-from-trap instructions of a hart that has only two privilege levels, machine and user. It owns the current privilege register and the status fields that form the return stack: an interrupt enable and a saved ("previous") interrupt enable for each level, plus the saved privilege that a machine return restores. When the pipeline presents a return request, the unit decides in the same cycle whether the request is legal. An illegal request raises an illegal-instruction trap. A legal request supplies the resume address from the exception PC of the returning level, and the stack is popped at the next clock edge.

The unit also holds the interrupt-enable register. While the hart runs in user mode, the upper enable bits of that register cannot be changed. A plain write port for the status fields lets the surrounding core load the stack. Trap entry and interrupt arbitration belong to other blocks. The unit signals them through a one-cycle recheck strobe after every successful return.

Top module: `trp_return_unit`

## Requirements
- R1: After reset the privilege output reads 3 (machine), the status word reads 0x1800 (saved-privilege field in bits 12:11 equal to 3, every enable bit 0), the interrupt-enable register reads 0 and the recheck strobe is low.
- R2: The 2-bit return level is decoded as user when it is 0 and as machine when it is 1, 2 or 3.
- R3: A return whose decoded level is above the current privilege raises trap_o in the same cycle, with cause 2 and next-PC-valid low. No privilege bit or enable bit changes as a result of it.
- R4: A legal machine return loads the privilege from the saved-privilege field (bits 12:11) and then sets that field to 0 (user).
- R5: A legal machine return copies the machine saved-enable bit (bit 7) into the machine enable bit (bit 3) and sets bit 7 to 1.
- R6: A legal user return sets the privilege to 0, copies the user saved-enable bit (bit 4) into the user enable bit (bit 0) and sets bit 4 to 1, leaving the machine fields unchanged.
- R7: During a legal return, npc_valid_o is high in the same cycle, and next_pc_o equals mepc_i for a machine return or uepc_i for a user return. epc_addr_o equals 0x041 OR (decoded level shifted left by 8), which is 0x341 for machine and 0x041 for user.
- R8: An interrupt-enable write updates only the bits in the writable mask (default 0xBBB). While the privilege is user, bits 11:4 keep their old values.
- R9: recheck_o is high for exactly the one cycle after each legal return, and low after an illegal one.
- R10: A status write stores bits 0, 3, 4, 7 and 12:11 and reads 0 in every other bit. A saved-privilege value other than 3 is stored as 0.
- R11: When a legal return and a status write occur in the same cycle, the return's update is kept and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | Return instruction strobe |
| ret_level | input | 2 | Privilege level encoded in the return instruction |
| uepc_i | input | XLEN | User exception PC value |
| mepc_i | input | XLEN | Machine exception PC value |
| st_wr | input | 1 | Status word write enable |
| st_wdata | input | XLEN | Status word write data |
| ie_wr | input | 1 | Interrupt-enable register write enable |
| ie_wdata | input | XLEN | Interrupt-enable write data |
| priv_o | output | 2 | Current privilege (0 user, 3 machine) |
| status_o | output | XLEN | Status word |
| ie_o | output | XLEN | Interrupt-enable register |
| npc_valid_o | output | 1 | Legal return this cycle, next_pc_o valid |
| next_pc_o | output | XLEN | Resume address |
| epc_addr_o | output | 12 | CSR address of the selected exception PC |
| trap_o | output | 1 | Illegal-return trap pulse |
| trap_cause_o | output | CAUSE_W | Trap cause (2 when trap_o is high) |
| recheck_o | output | 1 | Interrupt re-evaluation strobe |

## Verification
Two situations are hard to reach from the ports. The first is an illegal machine return: the privilege can only be lowered by a return, so the stimulus must first load a saved privilege of 0 and then perform a machine return that drops the hart into user mode. Only from user mode can the illegal request, and the locked user-mode writes to the interrupt-enable register, be exercised. Getting back to machine mode takes a second reset. The stimulus also includes a same-cycle collision between a return and a status write.

// File: rtl/trp_pkg.sv
package trp_pkg;
   typedef enum logic [1:0] {
      PRV_U = 2'b00,
      PRV_M = 2'b11
   } priv_e;

   localparam int UIE_BIT  = 0;
   localparam int MIE_BIT  = 3;
   localparam int UPIE_BIT = 4;
   localparam int MPIE_BIT = 7;
   localparam int MPP_LO   = 11;
   localparam int MPP_HI   = 12;

   localparam int          EPC_ADDR_W      = 12;
   localparam logic [11:0] EPC_USER_ADDR   = 12'h041;
   localparam int          ILLEGAL_INSN_CS = 2;

   function automatic priv_e decode_level(input logic [1:0] lvl);
      return (lvl == 2'b00) ? PRV_U : PRV_M;
   endfunction
endpackage

// File: rtl/trp_priv_check.sv
module trp_priv_check
   import trp_pkg::*;
(
   input  logic       ret_valid,
   input  logic [1:0] ret_level,
   input  priv_e      cur_priv,
   output priv_e      ret_priv,
   output logic       ret_m_ok,
   output logic       ret_u_ok,
   output logic       illegal
);
   logic above;

   always_comb begin
      ret_priv = decode_level(ret_level);
      above    = 2'(ret_priv) > 2'(cur_priv);
      illegal  = ret_valid && above;
      ret_m_ok = ret_valid && !above && (ret_priv == PRV_M);
      ret_u_ok = ret_valid && !above && (ret_priv == PRV_U);
   end
endmodule

// File: rtl/trp_status_stack.sv
module trp_status_stack
   import trp_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ret_m_ok,
   input  logic            ret_u_ok,
   input  logic            st_wr,
   input  logic [XLEN-1:0] st_wdata,
   output priv_e           priv_q,
   output logic [XLEN-1:0] status_q
);
   logic [1:0] mpp_r;
   logic       mie_r, mpie_r, uie_r, upie_r;
   priv_e      priv_r;
   logic [1:0] wr_mpp;

   assign wr_mpp = (st_wdata[MPP_HI:MPP_LO] == 2'b11) ? 2'b11 : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         priv_r <= PRV_M;
         mpp_r  <= 2'b11;
         mie_r  <= 1'b0;
         mpie_r <= 1'b0;
         uie_r  <= 1'b0;
         upie_r <= 1'b0;
      end else if (ret_m_ok) begin
         priv_r <= priv_e'(mpp_r);
         mpp_r  <= 2'b00;
         mie_r  <= mpie_r;
         mpie_r <= 1'b1;
      end else if (ret_u_ok) begin
         priv_r <= PRV_U;
         uie_r  <= upie_r;
         upie_r <= 1'b1;
      end else if (st_wr) begin
         mpp_r  <= wr_mpp;
         mie_r  <= st_wdata[MIE_BIT];
         mpie_r <= st_wdata[MPIE_BIT];
         uie_r  <= st_wdata[UIE_BIT];
         upie_r <= st_wdata[UPIE_BIT];
      end
   end

   always_comb begin
      status_q                = '0;
      status_q[UIE_BIT]       = uie_r;
      status_q[MIE_BIT]       = mie_r;
      status_q[UPIE_BIT]      = upie_r;
      status_q[MPIE_BIT]      = mpie_r;
      status_q[MPP_HI:MPP_LO] = mpp_r;
   end

   assign priv_q = priv_r;

   // R4
   mret_mpp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_m_ok |=> (mpp_r == 2'b00) && (2'(priv_r) == $past(mpp_r)));
   // R5
   mret_ie_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_m_ok |=> mpie_r && (mie_r == $past(mpie_r)));
   // R6
   uret_ie_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_u_ok |=> upie_r && (uie_r == $past(upie_r)) && (priv_r == PRV_U)
                   && $stable(mpp_r) && $stable(mie_r));
   // R4
   priv_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_r == PRV_U) || (priv_r == PRV_M));
   // R10
   mpp_warl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && !ret_m_ok && !ret_u_ok && (st_wdata[MPP_HI:MPP_LO] != 2'b11))
      |=> (mpp_r == 2'b00));
endmodule

// File: rtl/trp_ie_reg.sv
module trp_ie_reg #(
   parameter int              XLEN         = 32,
   parameter logic [XLEN-1:0] IE_WMASK     = XLEN'(12'hBBB),
   parameter bit              USER_IE_LOCK = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ie_wr,
   input  logic [XLEN-1:0] ie_wdata,
   input  logic            user_mode,
   output logic [XLEN-1:0] ie_q
);
   localparam logic [XLEN-1:0] LOCK_MASK = XLEN'(12'hFF0);

   logic [XLEN-1:0] eff_mask;

   generate
      if (USER_IE_LOCK) begin : g_lock
         assign eff_mask = user_mode ? (IE_WMASK & ~LOCK_MASK) : IE_WMASK;

         // R8
         user_ie_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ie_wr && user_mode) |=> (ie_q[11:4] == $past(ie_q[11:4])));
      end else begin : g_open
         assign eff_mask = IE_WMASK;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ie_q <= '0;
      else if (ie_wr) ie_q <= (ie_q & ~eff_mask) | (ie_wdata & eff_mask);
   end
endmodule

// File: rtl/trp_return_unit.sv
module trp_return_unit
   import trp_pkg::*;
#(
   parameter int              XLEN         = 32,
   parameter int              CAUSE_W      = 8,
   parameter logic [XLEN-1:0] IE_WMASK     = XLEN'(12'hBBB),
   parameter bit              USER_IE_LOCK = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ret_valid,
   input  logic [1:0]            ret_level,
   input  logic [XLEN-1:0]       uepc_i,
   input  logic [XLEN-1:0]       mepc_i,
   input  logic                  st_wr,
   input  logic [XLEN-1:0]       st_wdata,
   input  logic                  ie_wr,
   input  logic [XLEN-1:0]       ie_wdata,
   output logic [1:0]            priv_o,
   output logic [XLEN-1:0]       status_o,
   output logic [XLEN-1:0]       ie_o,
   output logic                  npc_valid_o,
   output logic [XLEN-1:0]       next_pc_o,
   output logic [EPC_ADDR_W-1:0] epc_addr_o,
   output logic                  trap_o,
   output logic [CAUSE_W-1:0]    trap_cause_o,
   output logic                  recheck_o
);
   localparam logic [CAUSE_W-1:0] CAUSE_ILL = CAUSE_W'(ILLEGAL_INSN_CS);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("trp_return_unit: XLEN must be 32 or 64");
      end
      if (CAUSE_W < 2) begin : g_bad_cause
         $error("trp_return_unit: CAUSE_W too narrow for the cause code");
      end
   endgenerate

   priv_e cur_priv, ret_priv;
   logic  ret_m_ok, ret_u_ok, illegal;
   logic  recheck_q;

   trp_priv_check u_check (
      .ret_valid (ret_valid),
      .ret_level (ret_level),
      .cur_priv  (cur_priv),
      .ret_priv  (ret_priv),
      .ret_m_ok  (ret_m_ok),
      .ret_u_ok  (ret_u_ok),
      .illegal   (illegal)
   );

   trp_status_stack #(.XLEN(XLEN)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .ret_m_ok (ret_m_ok),
      .ret_u_ok (ret_u_ok),
      .st_wr    (st_wr),
      .st_wdata (st_wdata),
      .priv_q   (cur_priv),
      .status_q (status_o)
   );

   trp_ie_reg #(
      .XLEN         (XLEN),
      .IE_WMASK     (IE_WMASK),
      .USER_IE_LOCK (USER_IE_LOCK)
   ) u_ie (
      .clk       (clk),
      .rst_n     (rst_n),
      .ie_wr     (ie_wr),
      .ie_wdata  (ie_wdata),
      .user_mode (cur_priv == PRV_U),
      .ie_q      (ie_o)
   );

   always_comb begin
      npc_valid_o  = ret_m_ok || ret_u_ok;
      next_pc_o    = (ret_priv == PRV_M) ? mepc_i : uepc_i;
      epc_addr_o   = EPC_USER_ADDR | (EPC_ADDR_W'(2'(ret_priv)) << 8);
      trap_o       = illegal;
      trap_cause_o = illegal ? CAUSE_ILL : '0;
      priv_o       = 2'(cur_priv);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) recheck_q <= 1'b0;
      else        recheck_q <= ret_m_ok || ret_u_ok;
   end
   assign recheck_o = recheck_q;

   // R3
   trap_no_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_o && !st_wr) |=> ($stable(status_o) && $stable(priv_o)));
   // R3
   trap_priv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |=> $stable(priv_o));
   // R7
   epc_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (npc_valid_o && ret_level == 2'b00) |-> (next_pc_o == uepc_i));
   // R9
   recheck_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |=> !recheck_o);
endmodule

// File: tb/tb_trp_return_unit.sv
`timescale 1ns/1ps
module tb_trp_return_unit;
   localparam int XLEN = 32;
   localparam int CW   = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ret_valid = 1'b0;
   logic [1:0]      ret_level = 2'b00;
   logic [XLEN-1:0] uepc_i = '0, mepc_i = '0, st_wdata = '0, ie_wdata = '0;
   logic            st_wr = 1'b0, ie_wr = 1'b0;
   logic [1:0]      priv_o;
   logic [XLEN-1:0] status_o, ie_o, next_pc_o;
   logic            npc_valid_o, trap_o, recheck_o;
   logic [11:0]     epc_addr_o;
   logic [CW-1:0]   trap_cause_o;

   trp_return_unit #(.XLEN(XLEN), .CAUSE_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_level(ret_level),
      .uepc_i(uepc_i), .mepc_i(mepc_i), .st_wr(st_wr), .st_wdata(st_wdata),
      .ie_wr(ie_wr), .ie_wdata(ie_wdata), .priv_o(priv_o), .status_o(status_o),
      .ie_o(ie_o), .npc_valid_o(npc_valid_o), .next_pc_o(next_pc_o),
      .epc_addr_o(epc_addr_o), .trap_o(trap_o), .trap_cause_o(trap_cause_o),
      .recheck_o(recheck_o)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int          cyc;
      int          sig;
      logic [63:0] val;
      string       req;
   } exp_t;

   exp_t q[$];
   int   total = 0, bad = 0;
   bit   finished = 1'b0;

   // model of the architectural state
   logic [1:0]  m_priv, m_mpp;
   logic        m_mie, m_mpie, m_uie, m_upie;
   logic [31:0] m_ie;

   function automatic logic [31:0] m_status();
      return {19'd0, m_mpp, 3'd0, m_mpie, 2'd0, m_upie, m_mie, 2'd0, m_uie};
   endfunction

   function automatic logic [63:0] actual(input int s);
      case (s)
         0: return 64'(priv_o);
         1: return 64'(status_o);
         2: return 64'(ie_o);
         3: return 64'(trap_o);
         4: return 64'(trap_cause_o);
         5: return 64'(npc_valid_o);
         6: return 64'(next_pc_o);
         7: return 64'(epc_addr_o);
         default: return 64'(recheck_o);
      endcase
   endfunction

   function automatic string sname(input int s);
      case (s)
         0: return "priv";
         1: return "status";
         2: return "ie";
         3: return "trap";
         4: return "cause";
         5: return "npc_valid";
         6: return "next_pc";
         7: return "epc_addr";
         default: return "recheck";
      endcase
   endfunction

   task automatic push(input int c, input int s, input logic [63:0] v, input string r);
      exp_t e;
      e.cyc = c; e.sig = s; e.val = v; e.req = r;
      q.push_back(e);
   endtask

   task automatic push_state(input int c, input string r);
      push(c, 0, 64'(m_priv), r);
      push(c, 1, 64'(m_status()), r);
      push(c, 2, 64'(m_ie), r);
   endtask

   // monitor: pops due expectations and compares
   initial begin
      forever begin
         @(negedge clk);
         while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (actual(e.sig) !== e.val) begin
               bad++;
               $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)",
                        e.req, sname(e.sig), actual(e.sig), e.val, cyc);
            end
         end
      end
   end

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0; ret_valid = 0; st_wr = 0; ie_wr = 0;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b1;
      m_priv = 2'd3; m_mpp = 2'd3; m_mie = 0; m_mpie = 0; m_uie = 0; m_upie = 0;
      m_ie = 32'h0;
      // R1: reset state
      push_state(cyc, "R1");
      push(cyc, 8, 0, "R1");
      push(cyc, 3, 0, "R1");
   endtask

   // driver: applies one operation and queues the expected results
   task automatic step(input string r, input bit do_ret, input logic [1:0] lvl,
                       input bit do_st, input logic [31:0] sd,
                       input bit do_ie, input logic [31:0] idata,
                       input logic [31:0] ue, input logic [31:0] me);
      bit          lm, ill, ok;
      logic [31:0] mask;
      @(posedge clk); #1;
      ret_valid = do_ret; ret_level = lvl; st_wr = do_st; st_wdata = sd;
      ie_wr = do_ie; ie_wdata = idata; uepc_i = ue; mepc_i = me;
      lm  = (lvl != 2'b00);                 // R2 decode
      ill = do_ret && lm && (m_priv == 2'd0);
      ok  = do_ret && !ill;
      push(cyc, 8, 0, "R9");
      push(cyc, 3, 64'(ill), r);
      push(cyc, 4, ill ? 64'd2 : 64'd0, r);
      push(cyc, 5, 64'(ok), r);
      if (ok) begin
         // R7
         push(cyc, 6, lm ? 64'(me) : 64'(ue), r);
         push(cyc, 7, lm ? 64'h341 : 64'h041, r);
      end
      if (do_ie) begin
         mask = 32'hBBB;
         if (m_priv == 2'd0) mask = mask & ~32'hFF0;
         m_ie = (m_ie & ~mask) | (idata & mask);
      end
      if (ok && lm) begin
         m_priv = m_mpp; m_mpp = 2'd0; m_mie = m_mpie; m_mpie = 1'b1;
      end else if (ok) begin
         m_priv = 2'd0; m_uie = m_upie; m_upie = 1'b1;
      end else if (do_st) begin
         m_mpp  = (sd[12:11] == 2'b11) ? 2'd3 : 2'd0;
         m_mie  = sd[3]; m_mpie = sd[7]; m_uie = sd[0]; m_upie = sd[4];
      end
      push_state(cyc + 1, r);
      push(cyc + 1, 8, 64'(ok), "R9");
      @(posedge clk); #1;
      ret_valid = 0; st_wr = 0; ie_wr = 0;
   endtask

   initial begin
      do_reset();
      // R10: saved privilege 1 legalizes to 0
      step("R10", 0, 2'd0, 1, 32'h0000_0880, 0, 0, 0, 0);
      // R10: only the five fields are stored
      step("R10", 0, 2'd0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
      step("R10", 0, 2'd0, 1, 32'h0000_1810, 0, 0, 0, 0);
      // R4 R5 R7: machine return that stays in machine mode
      step("R4", 1, 2'd3, 0, 0, 0, 0, 32'h0000_1100, 32'h0000_2200);
      // R8: machine-mode write of every bit
      step("R8", 0, 2'd0, 0, 0, 1, 32'hFFFF_FFFF, 0, 0);
      // R11: return plus status write in one cycle; drops to user
      step("R11", 1, 2'd1, 1, 32'h0000_1808, 0, 0, 32'h0000_1104, 32'h0000_2204);
      // R3: machine return from user traps
      step("R3", 1, 2'd3, 0, 0, 0, 0, 32'h0000_1108, 32'h0000_2208);
      // R2: level 2 also decodes as machine, so it traps too
      step("R2", 1, 2'd2, 0, 0, 0, 0, 32'h0000_110C, 32'h0000_220C);
      // R8: user-mode write keeps bits 11:4
      step("R8", 0, 2'd0, 0, 0, 1, 32'h0000_0000, 0, 0);
      // R6 R7: user return
      step("R6", 1, 2'd0, 0, 0, 0, 0, 32'h0000_1110, 32'h0000_2210);
      // R9: idle cycle, no strobe
      step("R9", 0, 2'd0, 0, 0, 0, 0, 0, 0);
      do_reset();
      // R5: enable pop with saved enable 0
      step("R5", 0, 2'd0, 1, 32'h0000_1808, 0, 0, 0, 0);
      step("R5", 1, 2'd2, 0, 0, 0, 0, 32'h0000_1120, 32'h0000_2220);
      // R2: level 0 from machine is a legal user return
      step("R2", 1, 2'd0, 0, 0, 0, 0, 32'h0000_1124, 32'h0000_2224);
      // R7: level 1 from user is illegal, no PC
      step("R7", 1, 2'd1, 0, 0, 0, 0, 32'h0000_1128, 32'h0000_2228);
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         bad++;
         $display("FAIL R1 watchdog act=running exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule